// File: doc/BRIEF.md
# Vector Indexed Atomic Read-Modify-Write Sequencer

This block carries out one vector atomic memory instruction, one element at a time. A start command supplies a base address, an operation code, a memory width (32 or 64 bits), an element count and two flags. The first flag selects masking and the second selects old-value writeback. For every active element the sequencer reads that element's index and source value from the vector register port. The target address is the base plus the index. The sequencer reads the memory word there, combines it with the source value, and writes the result back to the same address. If writeback is selected, it then puts the value it read from memory into the same vector element.

Elements run in ascending order. Each element is one locked read followed by one write. The sequencer promises no acquire or release ordering for an element, and no ordering between elements beyond the fact that it runs them one after another. Once the active elements are done, every element from the count up to the register's capacity is cleared to zero, and a one-cycle done pulse ends the command.

Top module: `vamo_seq`

## Requirements
- R1: The address of element i is `cmd_base + er_index[ADDR_W-1:0]`. Because this is two's complement arithmetic, a negative 64-bit index lowers the address.
- R2: Operation codes on `cmd_op` are 0 swap (result = source), 1 add, 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min and 8 unsigned max. Codes 9 to 15 act as swap. The written value is op(memory, source), computed at the memory width.
- R3: When the two operands compare equal, min and max return the memory value. Signed and unsigned compares give different results when the operands' sign bits differ.
- R4: With `cmd_wd`=1, an active element receives the old memory value. With `cmd_wd`=0 it keeps its previous contents.
- R5: With `cmd_masked`=1, an element whose `er_mask` bit is 0 makes no memory access and keeps its previous contents. With `cmd_masked`=0 every element below the count is active.
- R6: With `cmd_w64`=0, the sequencer uses only bits 31:0 of `mem_rdata`. It sign-extends the old word into the 64-bit element, and it writes a 32-bit result with `mem_w64`=0 and zero upper data bits.
- R7: After the active elements, elements from the effective count up to VLMAX-1 are written with zero. A `cmd_vl` above VLMAX is treated as VLMAX, and a count of 0 makes no memory access.
- R8: Each active element issues a read and then a write to the same address. `mem_lock` stays high from the read until the write is acknowledged. A request, once raised, keeps its address until `mem_ack`.
- R9: `busy` is high from the cycle after an accepted start until the command ends. `done` is a single-cycle pulse after tail clearing, with `busy` low. A start seen while busy is ignored.
- R10: After reset the sequencer is idle: `busy`, `done`, `mem_req` and `er_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 4 | Operation code |
| cmd_wd | input | 1 | Write old memory value into element |
| cmd_masked | input | 1 | Honour per-element mask |
| cmd_w64 | input | 1 | 1: 64-bit memory width, 0: 32-bit |
| cmd_vl | input | CNT_W | Active element count |
| cmd_base | input | ADDR_W | Base byte address |
| busy | output | 1 | Command in progress |
| done | output | 1 | End-of-command pulse |
| er_idx | output | IDX_W | Element index for register read and write |
| er_index | input | 64 | Index value of element er_idx |
| er_src | input | 64 | Source value of element er_idx |
| er_mask | input | 1 | Mask bit of element er_idx |
| er_we | output | 1 | Element write enable |
| er_wdata | output | 64 | Element write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_w64 | output | 1 | Access width is 64 bits |
| mem_lock | output | 1 | Port held across read and write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 64 | Read data |

## Verification
Two functions share one cycle. The writeback of element i's old value into its register happens in the same cycle as the acknowledge of that element's memory write. When two elements carry the same index, the read for the second element follows straight after that shared cycle, so the second element must see the first element's result in memory. Directed runs with repeated indices and writeback enabled provoke this case. Random runs also draw colliding indices and vary the acknowledge latency. The bench judges each run by comparing the final memory image and every register element with a sequential model that works in ascending element order.

// File: rtl/vamo_seq.sv
module vamo_seq #(
  parameter int ADDR_W = 32,
  parameter int VLMAX  = 8,
  localparam int IDX_W = $clog2(VLMAX),
  localparam int CNT_W = $clog2(VLMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cmd_op,
  input  logic              cmd_wd,
  input  logic              cmd_masked,
  input  logic              cmd_w64,
  input  logic [CNT_W-1:0]  cmd_vl,
  input  logic [ADDR_W-1:0] cmd_base,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  er_idx,
  input  logic [63:0]       er_index,
  input  logic [63:0]       er_src,
  input  logic              er_mask,
  output logic              er_we,
  output logic [63:0]       er_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_w64,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);
  localparam logic [CNT_W-1:0] VMAX = CNT_W'(VLMAX);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_RD, S_WR, S_TAIL} st_t;
  st_t st;

  logic [CNT_W-1:0]  cnt, vl_q;
  logic [3:0]        op_q;
  logic              wd_q, msk_q, w64_q, done_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [63:0]       src_q, old_q, new_q;

  logic [63:0] a_s, b_s, a_u, b_u, res;
  logic        b_lt_a_s, a_lt_b_s, b_lt_a_u, a_lt_b_u;

  assign a_s = w64_q ? mem_rdata : {{32{mem_rdata[31]}}, mem_rdata[31:0]};
  assign b_s = w64_q ? src_q     : {{32{src_q[31]}}, src_q[31:0]};
  assign a_u = w64_q ? mem_rdata : {32'b0, mem_rdata[31:0]};
  assign b_u = w64_q ? src_q     : {32'b0, src_q[31:0]};
  assign b_lt_a_s = $signed(b_s) < $signed(a_s);
  assign a_lt_b_s = $signed(a_s) < $signed(b_s);
  assign b_lt_a_u = b_u < a_u;
  assign a_lt_b_u = a_u < b_u;

  always_comb begin
    case (op_q)
      4'd1:    res = a_s + b_s;
      4'd2:    res = a_s ^ b_s;
      4'd3:    res = a_s & b_s;
      4'd4:    res = a_s | b_s;
      4'd5:    res = b_lt_a_s ? b_s : a_s;
      4'd6:    res = a_lt_b_s ? b_s : a_s;
      4'd7:    res = b_lt_a_u ? b_u : a_u;
      4'd8:    res = a_lt_b_u ? b_u : a_u;
      default: res = b_s;
    endcase
  end

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign er_idx    = cnt[IDX_W-1:0];
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = st == S_WR;
  assign mem_lock  = mem_req;
  assign mem_w64   = w64_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign er_we     = (st == S_WR && mem_ack && wd_q) || (st == S_TAIL && cnt < VMAX);
  assign er_wdata  = (st == S_TAIL) ? 64'b0 : old_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; vl_q <= '0; op_q <= '0;
      wd_q <= 1'b0; msk_q <= 1'b0; w64_q <= 1'b0; done_q <= 1'b0;
      base_q <= '0; addr_q <= '0; src_q <= '0; old_q <= '0; new_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SEL;
          cnt    <= '0;
          vl_q   <= (cmd_vl > VMAX) ? VMAX : cmd_vl;
          op_q   <= cmd_op;
          wd_q   <= cmd_wd;
          msk_q  <= cmd_masked;
          w64_q  <= cmd_w64;
          base_q <= cmd_base;
        end
        S_SEL: begin
          if (cnt >= vl_q) st <= S_TAIL;
          else if (msk_q && !er_mask) cnt <= cnt + 1'b1;
          else begin
            addr_q <= base_q + er_index[ADDR_W-1:0];
            src_q  <= er_src;
            st     <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          old_q <= a_s;
          new_q <= w64_q ? res : {32'b0, res[31:0]};
          st    <= S_WR;
        end
        S_WR: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          st  <= S_SEL;
        end
        S_TAIL: begin
          if (cnt >= VMAX) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_rmw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_lock && $stable(mem_addr)));
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !er_we && !mem_req));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !er_we));
  a_r4_wb_at_write: assert property (@(posedge clk) disable iff (!rst_n)
    (er_we && er_wdata != 64'b0) |-> (mem_req && mem_we && mem_ack));
endmodule

// File: tb/vamo_seq_bench.sv
module vamo_seq_bench;
  localparam int AW = 32;
  localparam int VLM = 8;
  localparam int CW = $clog2(VLM + 1);
  localparam int IW = $clog2(VLM);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cmd_wd = 1'b0, cmd_masked = 1'b0, cmd_w64 = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [CW-1:0] cmd_vl = '0;
  logic [AW-1:0] cmd_base = '0;
  logic busy, done, er_we, mem_req, mem_we, mem_w64, mem_lock, er_mask;
  logic [IW-1:0] er_idx;
  logic [63:0] er_index, er_src, er_wdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  vamo_seq #(.ADDR_W(AW), .VLMAX(VLM)) u_vamo_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_wd(cmd_wd),
    .cmd_masked(cmd_masked), .cmd_w64(cmd_w64), .cmd_vl(cmd_vl), .cmd_base(cmd_base),
    .busy(busy), .done(done), .er_idx(er_idx), .er_index(er_index), .er_src(er_src),
    .er_mask(er_mask), .er_we(er_we), .er_wdata(er_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_w64(mem_w64), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [31:0] mem [256];
  logic [63:0] vreg [VLM];
  logic [63:0] vidx [VLM];
  logic        vmask [VLM];
  int rd_cnt = 0, wait_n = 0, total = 0, bad = 0;

  assign er_index = vidx[er_idx];
  assign er_src   = vreg[er_idx];
  assign er_mask  = vmask[er_idx];

  always @(posedge clk) begin
    logic [7:0] wa;
    wa = mem_addr[9:2];
    if (er_we) vreg[er_idx] <= er_wdata;
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_n > 0) wait_n <= wait_n - 1;
      else begin
        mem_ack <= 1'b1;
        wait_n  <= int'($urandom % 3);
        if (mem_we) begin
          mem[wa] <= mem_wdata[31:0];
          if (mem_w64) mem[wa + 8'd1] <= mem_wdata[63:32];
        end else begin
          mem_rdata <= {mem_w64 ? mem[wa + 8'd1] : $urandom, mem[wa]};
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] op_calc(logic [3:0] op, bit w64, logic [63:0] m, logic [63:0] s);
    logic signed [63:0] sm, ss;
    logic [63:0] um, us, r;
    sm = w64 ? m : {{32{m[31]}}, m[31:0]};
    ss = w64 ? s : {{32{s[31]}}, s[31:0]};
    um = w64 ? m : {32'b0, m[31:0]};
    us = w64 ? s : {32'b0, s[31:0]};
    case (op)
      4'd1: r = m + s;
      4'd2: r = m ^ s;
      4'd3: r = m & s;
      4'd4: r = m | s;
      4'd5: r = (ss < sm) ? ss : sm;
      4'd6: r = (ss > sm) ? ss : sm;
      4'd7: r = (us < um) ? us : um;
      4'd8: r = (us > um) ? us : um;
      default: r = s;
    endcase
    return w64 ? r : {32'b0, r[31:0]};
  endfunction

  task automatic run_cmd(input logic [3:0] op, input bit wd, input bit msk, input bit w64,
                         input int vl, input logic [31:0] base, input bit poke, input string tag);
    logic [31:0] em [256];
    logic [63:0] er [VLM];
    logic [63:0] m, nv, old;
    logic [31:0] addr;
    logic [7:0] a;
    int eff, acc, rd0, t;
    bit mem_ok;
    for (int k = 0; k < 256; k++) em[k] = mem[k];
    for (int k = 0; k < VLM; k++) er[k] = vreg[k];
    eff = (vl > VLM) ? VLM : vl;
    acc = 0;
    for (int i = 0; i < eff; i++) begin
      if (msk && !vmask[i]) continue;
      addr = base + vidx[i][31:0];
      a = addr[9:2];
      m = w64 ? {em[a + 8'd1], em[a]} : {32'b0, em[a]};
      old = w64 ? m : {{32{m[31]}}, m[31:0]};
      nv = op_calc(op, w64, m, er[i]);
      em[a] = nv[31:0];
      if (w64) em[a + 8'd1] = nv[63:32];
      if (wd) er[i] = old;
      acc++;
    end
    for (int i = eff; i < VLM; i++) er[i] = '0;
    rd0 = rd_cnt;
    @(negedge clk);
    cmd_op = op; cmd_wd = wd; cmd_masked = msk; cmd_w64 = w64;
    cmd_vl = CW'(vl); cmd_base = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {"R9 busy after start ", tag}, 64'(busy), 64'd1);
    if (poke) begin
      @(negedge clk);
      cmd_op = 4'd0; cmd_wd = 1'b1; cmd_vl = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, {"R9 done timeout ", tag}, 64'(t), 64'd0);
    chk(busy === 1'b0, {"R9 idle at done ", tag}, 64'(busy), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, {"R9 done single cycle ", tag}, 64'(done), 64'd0);
    for (int i = 0; i < VLM; i++)
      chk(vreg[i] === er[i], (i >= eff) ? {"R7 tail zero ", tag} : {"R4 element ", tag}, vreg[i], er[i]);
    mem_ok = 1'b1;
    for (int k = 0; k < 256; k++)
      if (mem[k] !== em[k]) begin
        if (mem_ok) chk(1'b0, {"R2 memory image ", tag}, 64'(mem[k]), 64'(em[k]));
        mem_ok = 1'b0;
      end
    if (mem_ok) chk(1'b1, {"R2 memory image ", tag}, '0, '0);
    chk((rd_cnt - rd0) == acc, {"R5 access count ", tag}, 64'(rd_cnt - rd0), 64'(acc));
  endtask

  task automatic fill_regs(input bit w64);
    for (int i = 0; i < VLM; i++) begin
      vreg[i]  = {$urandom, $urandom};
      vidx[i]  = 64'(($signed(int'($urandom % 32)) - 16) * (w64 ? 8 : 4));
      vmask[i] = 1'($urandom);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 256; k++) mem[k] = $urandom;
    for (int i = 0; i < VLM; i++) begin vreg[i] = '0; vidx[i] = '0; vmask[i] = 1'b1; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && er_we === 1'b0, "R10 reset idle",
        {busy, done, mem_req, er_we}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 negative and positive indices, 64-bit add with writeback
    fill_regs(1'b1);
    vidx[0] = 64'd0; vidx[1] = 64'd8; vidx[2] = -64'sd8; vidx[3] = 64'd16;
    run_cmd(4'd1, 1'b1, 1'b0, 1'b1, 4, 32'h200, 1'b0, "R1 index add");

    // R3 ties keep memory, signed vs unsigned on differing signs (32-bit)
    for (int op = 5; op <= 8; op++) begin
      mem[8'h80] = 32'h0000_0055; mem[8'h81] = 32'hFFFF_FFFF;
      vidx[0] = 64'd0; vidx[1] = 64'd4; vreg[0] = 64'h55; vreg[1] = 64'h1;
      run_cmd(4'(op), 1'b1, 1'b0, 1'b0, 2, 32'h200, 1'b0, "R3 minmax tie/sign");
    end
    // R6 32-bit: negative word sign-extended into element
    mem[8'h90] = 32'h8000_0001;
    vidx[0] = 64'h40; vreg[0] = 64'hFFFF_FFFF_0000_0002;
    run_cmd(4'd4, 1'b1, 1'b0, 1'b0, 1, 32'h200, 1'b0, "R6 word sext");
    // R5 masked elements skipped
    fill_regs(1'b1);
    for (int i = 0; i < VLM; i++) vmask[i] = i[0];
    run_cmd(4'd2, 1'b1, 1'b1, 1'b1, 6, 32'h200, 1'b0, "R5 masked");
    // R4 writeback disabled
    fill_regs(1'b1);
    run_cmd(4'd3, 1'b0, 1'b0, 1'b1, 5, 32'h200, 1'b0, "R4 no writeback");
    // R8 repeated index: each element sees previous result
    fill_regs(1'b1);
    for (int i = 0; i < VLM; i++) vidx[i] = 64'd24;
    run_cmd(4'd1, 1'b1, 1'b0, 1'b1, 8, 32'h200, 1'b0, "R8 same address");
    // R7 empty and oversized counts
    fill_regs(1'b0);
    run_cmd(4'd0, 1'b1, 1'b0, 1'b0, 0, 32'h200, 1'b0, "R7 zero count");
    fill_regs(1'b0);
    run_cmd(4'd6, 1'b1, 1'b0, 1'b0, 12, 32'h200, 1'b0, "R7 clamp");
    // R9 start while busy ignored
    fill_regs(1'b1);
    run_cmd(4'd8, 1'b1, 1'b0, 1'b1, 7, 32'h200, 1'b1, "R9 poke ignored");
    // R2 codes above 8 behave as swap
    fill_regs(1'b1);
    run_cmd(4'd13, 1'b1, 1'b0, 1'b1, 3, 32'h200, 1'b0, "R2 spare code");

    for (int n = 0; n < 40; n++) begin
      bit w;
      w = 1'($urandom);
      fill_regs(w);
      run_cmd(4'($urandom % 9), 1'($urandom), 1'($urandom), w, int'($urandom % 10),
              32'h200, 1'b0, "R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule